// File: doc/BRIEF.md
# Descriptor Table Address Generator

This block keeps the three descriptor-table registers of a segmented memory unit: a global table, an interrupt table and a local table. Given a 16-bit segment selector or an 8-bit interrupt vector, it returns the linear address of the selected 8-byte descriptor one cycle later. If the descriptor would reach past the table limit, it reports a fault instead.

Software writes the registers through a load port and reads them back through a store port. The global and interrupt registers each hold a base and a limit. The local register holds only a selector into the global table. Loading it makes the block issue a memory read for that global descriptor. The returned 64 bits are kept in a cache register, and the base and limit for the local table come from there.

The two low selector bits carry a requester privilege tag. The block passes them through untouched for a later privilege stage.

Top module: `desc_addr_gen`

## Requirements
- R1: After reset, every table register, the local selector and the descriptor cache are zero, and `busy`, `mem_req`, `out_valid`, `out_fault` and `out_null` are low.
- R2: A cycle with `ld_valid` high writes `ld_data` into the register chosen by `ld_sel`: 0 selects global, 1 selects interrupt, 2 selects local, and 3 writes nothing. For the global and interrupt registers the base is in bits 47:16 and the limit in bits 15:0. The local register takes bits 15:0. `st_data` shows the register chosen by `st_sel` with the same encoding (local zero-extended, 3 reads zero) and reflects a load from the following cycle on.
- R3: A selector lookup takes the index from bits 15:3 and uses the local table when bit 2 is 1, otherwise the global table. In the cycle after `lk_valid` it gives `out_valid` with `out_addr` = base + index×8.
- R4: A vector lookup (`lk_is_vec` high) addresses the interrupt table at base + vector×8, with the same one-cycle latency.
- R5: A lookup whose index×8+7 exceeds the selected limit gives `out_fault` and no `out_valid`. A value equal to the limit is accepted.
- R6: A global-table selector with index 0 gives `out_null` only: no `out_valid`, no `out_fault`.
- R7: The local selector changes only on a load with `ld_sel`=2. Loads to other tables leave the local selector and the cache untouched.
- R8: A local load raises `mem_req` for exactly the next cycle, with `mem_addr` = global base + index×8 (the global base as it was at the load). `busy` is high from that cycle until the cycle after `mem_rvalid` is seen. A local-table lookup made while `busy` gives neither `out_valid` nor `out_fault`.
- R9: For a selector lookup, `out_rpl` equals selector bits 1:0 in the result cycle. For a vector lookup it is 0.
- R10: Read data is stored only while `busy`. The local limit is taken from cache bits 15:0 and the local base from bits 47:16. `mem_rvalid` outside `busy` changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ld_valid | input | 1 | Register load strobe |
| ld_sel | input | 2 | Load target: 0 global, 1 interrupt, 2 local |
| ld_data | input | 48 | Load value |
| st_sel | input | 2 | Readback target |
| st_data | output | 48 | Readback value |
| lk_valid | input | 1 | Lookup strobe |
| lk_is_vec | input | 1 | Lookup uses the vector rather than the selector |
| lk_sel | input | 16 | Segment selector |
| lk_vec | input | 8 | Interrupt vector |
| out_valid | output | 1 | Translated address valid |
| out_addr | output | 32 | Descriptor linear address |
| out_fault | output | 1 | Limit violation |
| out_null | output | 1 | Null global selector |
| out_rpl | output | 2 | Privilege tag passed through |
| busy | output | 1 | Local descriptor fetch outstanding |
| mem_req | output | 1 | Descriptor read request pulse |
| mem_addr | output | 32 | Descriptor read address |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 64 | Read data |

## Verification
The hardest situations to reach from the ports are the busy window and the cases near it. These are a local lookup arriving while the fetch is outstanding, stray read data outside that window, and a new local load landing while a fetch is still pending. A directed sequence holds back the read response for several cycles and places local and global lookups inside that gap. A long seeded random phase then mixes loads, lookups and read responses at arbitrary moments, and a behavioural model is compared against the outputs on every cycle.

// File: rtl/desc_pkg.sv
package desc_pkg;
   localparam int unsigned DESC_SHIFT = 3;

   typedef enum logic [1:0] {
      TBL_GLOBAL = 2'd0,
      TBL_INTR   = 2'd1,
      TBL_LOCAL  = 2'd2,
      TBL_NONE   = 2'd3
   } tbl_e;

   typedef enum logic {
      FETCH_IDLE = 1'b0,
      FETCH_WAIT = 1'b1
   } fetch_e;
endpackage

// File: rtl/desc_tbl_reg.sv
module desc_tbl_reg #(
   parameter int unsigned BASE_W = 32,
   parameter int unsigned LIM_W  = 16,
   localparam int unsigned WORD_W = BASE_W + LIM_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ld_en,
   input  logic [WORD_W-1:0] ld_word,
   output logic [BASE_W-1:0] base_o,
   output logic [LIM_W-1:0]  limit_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_o  <= '0;
         limit_o <= '0;
      end else if (ld_en) begin
         base_o  <= ld_word[LIM_W +: BASE_W];
         limit_o <= ld_word[0 +: LIM_W];
      end
   end
endmodule

// File: rtl/desc_ldt_fetch.sv
module desc_ldt_fetch
   import desc_pkg::*;
#(
   parameter int unsigned SEL_W  = 16,
   parameter int unsigned BASE_W = 32,
   parameter int unsigned LIM_W  = 16,
   parameter int unsigned DESC_W = 64,
   localparam int unsigned IDX_W = SEL_W - 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ld_en,
   input  logic [SEL_W-1:0]  ld_sel_val,
   input  logic [BASE_W-1:0] gbase,
   input  logic              mem_rvalid,
   input  logic [DESC_W-1:0] mem_rdata,
   output logic [SEL_W-1:0]  ldt_sel,
   output logic              mem_req,
   output logic [BASE_W-1:0] mem_addr,
   output logic              busy,
   output logic [BASE_W-1:0] cbase,
   output logic [LIM_W-1:0]  clim
);
   fetch_e            state_q;
   logic [DESC_W-1:0] cache_q;
   logic [IDX_W-1:0]  fidx;
   logic [BASE_W-1:0] foff;

   assign fidx = ld_sel_val[SEL_W-1:3];
   assign foff = BASE_W'(fidx) << DESC_SHIFT;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= FETCH_IDLE;
         ldt_sel  <= '0;
         mem_req  <= 1'b0;
         mem_addr <= '0;
         cache_q  <= '0;
      end else begin
         mem_req <= 1'b0;
         if (ld_en) begin
            ldt_sel  <= ld_sel_val;
            mem_req  <= 1'b1;
            mem_addr <= gbase + foff;
            state_q  <= FETCH_WAIT;
         end else if (state_q == FETCH_WAIT && mem_rvalid) begin
            cache_q <= mem_rdata;
            state_q <= FETCH_IDLE;
         end
      end
   end

   assign busy  = (state_q == FETCH_WAIT);
   assign cbase = cache_q[LIM_W +: BASE_W];
   assign clim  = cache_q[0 +: LIM_W];
endmodule

// File: rtl/desc_lookup.sv
module desc_lookup
   import desc_pkg::*;
#(
   parameter int unsigned SEL_W  = 16,
   parameter int unsigned VEC_W  = 8,
   parameter int unsigned BASE_W = 32,
   parameter int unsigned LIM_W  = 16,
   localparam int unsigned IDX_W = SEL_W - 3,
   localparam int unsigned OFF_W = IDX_W + DESC_SHIFT + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              lk_valid,
   input  logic              lk_is_vec,
   input  logic [SEL_W-1:0]  lk_sel,
   input  logic [VEC_W-1:0]  lk_vec,
   input  logic [BASE_W-1:0] gbase,
   input  logic [LIM_W-1:0]  glim,
   input  logic [BASE_W-1:0] ibase,
   input  logic [LIM_W-1:0]  ilim,
   input  logic [BASE_W-1:0] lbase,
   input  logic [LIM_W-1:0]  llim,
   input  logic              ldt_busy,
   output logic              out_valid,
   output logic [BASE_W-1:0] out_addr,
   output logic              out_fault,
   output logic              out_null,
   output logic [1:0]        out_rpl
);
   logic [IDX_W-1:0]  idx;
   tbl_e              tsel;
   logic [BASE_W-1:0] base_c;
   logic [LIM_W-1:0]  lim_c;
   logic [OFF_W-1:0]  off_c, last_c;
   logic              fault_c, null_c, stall_c, ok_c;

   always_comb begin
      if (lk_is_vec) begin
         idx  = IDX_W'(lk_vec);
         tsel = TBL_INTR;
      end else begin
         idx  = lk_sel[SEL_W-1:3];
         tsel = lk_sel[2] ? TBL_LOCAL : TBL_GLOBAL;
      end
      case (tsel)
         TBL_INTR:  begin base_c = ibase; lim_c = ilim; end
         TBL_LOCAL: begin base_c = lbase; lim_c = llim; end
         default:   begin base_c = gbase; lim_c = glim; end
      endcase
   end

   assign off_c   = OFF_W'(idx) << DESC_SHIFT;
   assign last_c  = off_c + OFF_W'((1 << DESC_SHIFT) - 1);
   assign fault_c = last_c > OFF_W'(lim_c);
   assign null_c  = (tsel == TBL_GLOBAL) && (idx == '0);
   assign stall_c = (tsel == TBL_LOCAL) && ldt_busy;
   assign ok_c    = lk_valid && !null_c && !stall_c;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_fault <= 1'b0;
         out_null  <= 1'b0;
         out_addr  <= '0;
         out_rpl   <= '0;
      end else begin
         out_valid <= ok_c && !fault_c;
         out_fault <= ok_c && fault_c;
         out_null  <= lk_valid && null_c;
         out_addr  <= (ok_c && !fault_c) ? base_c + BASE_W'(off_c) : '0;
         out_rpl   <= (lk_valid && !lk_is_vec) ? lk_sel[1:0] : 2'b00;
      end
   end
endmodule

// File: rtl/desc_addr_gen.sv
module desc_addr_gen
   import desc_pkg::*;
#(
   parameter int unsigned SEL_W  = 16,
   parameter int unsigned VEC_W  = 8,
   parameter int unsigned BASE_W = 32,
   parameter int unsigned LIM_W  = 16,
   parameter int unsigned DESC_W = 64,
   localparam int unsigned TBL_W = BASE_W + LIM_W,
   localparam int unsigned N_REG = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ld_valid,
   input  logic [1:0]        ld_sel,
   input  logic [TBL_W-1:0]  ld_data,
   input  logic [1:0]        st_sel,
   output logic [TBL_W-1:0]  st_data,
   input  logic              lk_valid,
   input  logic              lk_is_vec,
   input  logic [SEL_W-1:0]  lk_sel,
   input  logic [VEC_W-1:0]  lk_vec,
   output logic              out_valid,
   output logic [BASE_W-1:0] out_addr,
   output logic              out_fault,
   output logic              out_null,
   output logic [1:0]        out_rpl,
   output logic              busy,
   output logic              mem_req,
   output logic [BASE_W-1:0] mem_addr,
   input  logic              mem_rvalid,
   input  logic [DESC_W-1:0] mem_rdata
);
   if (DESC_W < TBL_W) begin : g_bad_desc
      $error("descriptor width too small for base and limit");
   end
   if (SEL_W < 4) begin : g_bad_sel
      $error("selector width too small");
   end
   if (VEC_W > SEL_W - 3) begin : g_bad_vec
      $error("vector wider than the index field");
   end
   if (TBL_W < SEL_W) begin : g_bad_tbl
      $error("table word narrower than a selector");
   end

   logic [BASE_W-1:0] tb_base [N_REG];
   logic [LIM_W-1:0]  tb_lim  [N_REG];
   logic [SEL_W-1:0]  ldt_sel;
   logic [BASE_W-1:0] cbase;
   logic [LIM_W-1:0]  clim;

   for (genvar t = 0; t < N_REG; t++) begin : g_tbl
      desc_tbl_reg #(.BASE_W(BASE_W), .LIM_W(LIM_W)) u_reg (
         .clk     (clk),
         .rst_n   (rst_n),
         .ld_en   (ld_valid && (ld_sel == 2'(t))),
         .ld_word (ld_data),
         .base_o  (tb_base[t]),
         .limit_o (tb_lim[t])
      );
   end

   desc_ldt_fetch #(
      .SEL_W(SEL_W), .BASE_W(BASE_W), .LIM_W(LIM_W), .DESC_W(DESC_W)
   ) u_fetch (
      .clk        (clk),
      .rst_n      (rst_n),
      .ld_en      (ld_valid && (ld_sel == TBL_LOCAL)),
      .ld_sel_val (ld_data[SEL_W-1:0]),
      .gbase      (tb_base[TBL_GLOBAL]),
      .mem_rvalid (mem_rvalid),
      .mem_rdata  (mem_rdata),
      .ldt_sel    (ldt_sel),
      .mem_req    (mem_req),
      .mem_addr   (mem_addr),
      .busy       (busy),
      .cbase      (cbase),
      .clim       (clim)
   );

   desc_lookup #(
      .SEL_W(SEL_W), .VEC_W(VEC_W), .BASE_W(BASE_W), .LIM_W(LIM_W)
   ) u_look (
      .clk       (clk),
      .rst_n     (rst_n),
      .lk_valid  (lk_valid),
      .lk_is_vec (lk_is_vec),
      .lk_sel    (lk_sel),
      .lk_vec    (lk_vec),
      .gbase     (tb_base[TBL_GLOBAL]),
      .glim      (tb_lim[TBL_GLOBAL]),
      .ibase     (tb_base[TBL_INTR]),
      .ilim      (tb_lim[TBL_INTR]),
      .lbase     (cbase),
      .llim      (clim),
      .ldt_busy  (busy),
      .out_valid (out_valid),
      .out_addr  (out_addr),
      .out_fault (out_fault),
      .out_null  (out_null),
      .out_rpl   (out_rpl)
   );

   always_comb begin
      case (st_sel)
         TBL_GLOBAL: st_data = {tb_base[TBL_GLOBAL], tb_lim[TBL_GLOBAL]};
         TBL_INTR:   st_data = {tb_base[TBL_INTR], tb_lim[TBL_INTR]};
         TBL_LOCAL:  st_data = TBL_W'(ldt_sel);
         default:    st_data = '0;
      endcase
   end
endmodule

// File: rtl/desc_addr_gen_chk.sv
module desc_addr_gen_chk
   import desc_pkg::*;
#(
   parameter int unsigned SEL_W = 16,
   parameter int unsigned TBL_W = 48
) (
   input logic             clk,
   input logic             rst_n,
   input logic             ld_valid,
   input logic [1:0]       ld_sel,
   input logic [1:0]       st_sel,
   input logic [TBL_W-1:0] st_data,
   input logic             lk_valid,
   input logic             lk_is_vec,
   input logic [SEL_W-1:0] lk_sel,
   input logic             out_valid,
   input logic             out_fault,
   input logic             out_null,
   input logic [1:0]       out_rpl,
   input logic             busy,
   input logic             mem_req,
   input logic             mem_rvalid
);
   logic ld_local;
   assign ld_local = ld_valid && (ld_sel == TBL_LOCAL);

   p_fault_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
      out_fault |-> !out_valid);

   p_null_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
      out_null |-> !(out_valid || out_fault));

   p_req_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !ld_local) |=> !mem_req);

   p_req_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> busy);

   p_local_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && lk_valid && !lk_is_vec && lk_sel[2]) |=> !(out_valid || out_fault));

   p_rpl_pass_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (lk_valid && !lk_is_vec) |=> (out_rpl == $past(lk_sel[1:0])));

   p_ldt_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (st_sel == TBL_LOCAL && !ld_local) |=> (st_sel != TBL_LOCAL || $stable(st_data)));

   p_idle_stays_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !ld_local && mem_rvalid) |=> !busy);
endmodule

bind desc_addr_gen desc_addr_gen_chk #(.SEL_W(SEL_W), .TBL_W(TBL_W)) u_chk (.*);

// File: tb/desc_addr_gen_tb.sv
`timescale 1ns/1ps
module desc_addr_gen_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ld_valid = 0;
   logic [1:0]  ld_sel = 0;
   logic [47:0] ld_data = 0;
   logic [1:0]  st_sel = 0;
   logic [47:0] st_data;
   logic        lk_valid = 0, lk_is_vec = 0;
   logic [15:0] lk_sel = 0;
   logic [7:0]  lk_vec = 0;
   logic        out_valid, out_fault, out_null, busy, mem_req;
   logic [31:0] out_addr, mem_addr;
   logic [1:0]  out_rpl;
   logic        mem_rvalid = 0;
   logic [63:0] mem_rdata = 0;

   int checks = 0, errors = 0;
   bit done = 0;

   // reference state
   logic [31:0] m_gb = 0, m_ib = 0, m_maddr = 0, e_addr = 0;
   logic [15:0] m_gl = 0, m_il = 0, m_ldt = 0;
   logic [63:0] m_cache = 0;
   bit m_busy = 0, m_req = 0, e_valid = 0, e_fault = 0, e_null = 0;
   logic [1:0] e_rpl = 0;

   always #2.5 clk = ~clk;

   desc_addr_gen u_dut (.*);

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic model_update();
      logic [31:0] b; logic [15:0] l; logic [12:0] idx; logic [16:0] last;
      bit isnull, stall;
      logic [31:0] ogb = m_gb;
      bit obusy = m_busy;
      if (lk_is_vec) begin idx = 13'(lk_vec); b = m_ib; l = m_il; end
      else if (lk_sel[2]) begin idx = lk_sel[15:3]; b = m_cache[47:16]; l = m_cache[15:0]; end
      else begin idx = lk_sel[15:3]; b = m_gb; l = m_gl; end
      isnull = !lk_is_vec && !lk_sel[2] && idx == 0;
      stall  = !lk_is_vec && lk_sel[2] && obusy;
      last   = 17'(idx) * 8 + 7;
      e_valid = lk_valid && !isnull && !stall && (last <= 17'(l));
      e_fault = lk_valid && !isnull && !stall && (last > 17'(l));
      e_null  = lk_valid && isnull;
      e_addr  = e_valid ? b + 32'(idx) * 8 : 32'h0;
      e_rpl   = (lk_valid && !lk_is_vec) ? lk_sel[1:0] : 2'b00;
      m_req = 0;
      if (ld_valid && ld_sel == 2) begin
         m_ldt = ld_data[15:0];
         m_req = 1;
         m_maddr = ogb + 32'(ld_data[15:3]) * 8;
         m_busy = 1;
      end else if (obusy && mem_rvalid) begin
         m_cache = mem_rdata;
         m_busy = 0;
      end
      if (ld_valid && ld_sel == 0) begin m_gb = ld_data[47:16]; m_gl = ld_data[15:0]; end
      if (ld_valid && ld_sel == 1) begin m_ib = ld_data[47:16]; m_il = ld_data[15:0]; end
   endtask

   function automatic logic [47:0] exp_st(input logic [1:0] s);
      case (s)
         2'd0: return {m_gb, m_gl};
         2'd1: return {m_ib, m_il};
         2'd2: return {32'h0, m_ldt};
         default: return 48'h0;
      endcase
   endfunction

   task automatic compare_all();
      chk("R3 out_valid", 64'(out_valid), 64'(e_valid));
      chk("R3/R4 out_addr", 64'(out_addr), 64'(e_addr));
      chk("R5 out_fault", 64'(out_fault), 64'(e_fault));
      chk("R6 out_null", 64'(out_null), 64'(e_null));
      chk("R9 out_rpl", 64'(out_rpl), 64'(e_rpl));
      chk("R8 busy", 64'(busy), 64'(m_busy));
      chk("R8 mem_req", 64'(mem_req), 64'(m_req));
      if (m_req) chk("R8 mem_addr", 64'(mem_addr), 64'(m_maddr));
      chk("R2 st_data", 64'(st_data), 64'(exp_st(st_sel)));
   endtask

   task automatic tick();
      @(posedge clk);
      model_update();
      @(negedge clk);
      compare_all();
      ld_valid = 0; lk_valid = 0; mem_rvalid = 0;
   endtask

   task automatic load(input logic [1:0] s, input logic [47:0] d);
      ld_valid = 1; ld_sel = s; ld_data = d; tick();
   endtask

   task automatic look_sel(input logic [15:0] s);
      lk_valid = 1; lk_is_vec = 0; lk_sel = s; tick();
   endtask

   task automatic look_vec(input logic [7:0] v);
      lk_valid = 1; lk_is_vec = 1; lk_vec = v; tick();
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      // R1: reset state at the ports, every readback zero
      for (int s = 0; s < 4; s++) begin
         st_sel = 2'(s); #0.1;
         chk("R1 st_data after reset", 64'(st_data), 64'h0);
      end
      chk("R1 busy after reset", 64'(busy), 0);
      chk("R1 out_valid after reset", 64'(out_valid), 0);
      st_sel = 0;
      tick();
      // R2: loads and readback
      load(0, {32'h0010_0000, 16'h00FF});
      st_sel = 1;
      load(1, {32'h0000_8000, 16'h07FF});
      tick();
      // R3 / R5 / R6 / R9 on the global table
      look_sel(16'h0008);
      chk("R3 global idx1 addr", 64'(out_addr), 64'h0010_0008);
      look_sel(16'h00FB);
      chk("R5 last byte equal to limit accepted", 64'(out_valid), 1);
      chk("R9 rpl 3", 64'(out_rpl), 3);
      look_sel(16'h0100);
      chk("R5 index past limit faults", 64'(out_fault), 1);
      look_sel(16'h0003);
      chk("R6 null selector", 64'(out_null), 1);
      // R4 vectors
      look_vec(8'd0);
      chk("R4 vector 0", 64'(out_addr), 64'h8000);
      look_vec(8'd255);
      chk("R4 vector 255", 64'(out_addr), 64'h87F8);
      load(1, {32'h0000_8000, 16'h07F7});
      look_vec(8'd255);
      chk("R5 vector past shrunk limit", 64'(out_fault), 1);
      // local table before any fetch: cache zero, limit zero
      look_sel(16'h0004);
      chk("R10 empty cache faults", 64'(out_fault), 1);
      // R8 local fetch
      st_sel = 2;
      load(2, 48'h0018);
      chk("R8 request pulse", 64'(mem_req), 1);
      chk("R8 request address", 64'(mem_addr), 64'h0010_0018);
      look_sel(16'h000C);
      chk("R8 local lookup stalled", 64'(out_valid | out_fault), 0);
      look_sel(16'h0010);
      chk("R8 global lookup during fetch", 64'(out_addr), 64'h0010_0010);
      tick();
      mem_rvalid = 1; mem_rdata = {16'h0, 32'h0020_0000, 16'h001F};
      tick();
      chk("R8 busy cleared", 64'(busy), 0);
      look_sel(16'h000E);
      chk("R10 local base from cache", 64'(out_addr), 64'h0020_0008);
      look_sel(16'h001C);
      chk("R10 local limit boundary", 64'(out_addr), 64'h0020_0018);
      look_sel(16'h0024);
      chk("R10 local limit fault", 64'(out_fault), 1);
      // R10 stray read data ignored
      mem_rvalid = 1; mem_rdata = 64'hFFFF_FFFF_FFFF_FFFF;
      tick();
      look_sel(16'h000C);
      chk("R10 stray data ignored", 64'(out_addr), 64'h0020_0008);
      // R7 other loads leave the local selector alone
      load(0, {32'h0030_0000, 16'h0FFF});
      load(3, 48'hABCD_EF01_2345);
      chk("R7 local selector kept", 64'(st_data), 64'h0018);
      look_sel(16'h000C);
      chk("R7 cache kept", 64'(out_addr), 64'h0020_0008);
      // seeded random mix compared against the model every cycle
      void'($urandom(32'h1234_5678));
      for (int i = 0; i < 3000; i++) begin
         lk_valid  = ($urandom % 2) == 0;
         lk_is_vec = ($urandom % 4) == 0;
         lk_sel    = {13'($urandom % 48), 3'($urandom)};
         lk_vec    = 8'($urandom);
         st_sel    = 2'($urandom);
         ld_valid  = ($urandom % 12) == 0;
         ld_sel    = 2'($urandom);
         ld_data   = {32'($urandom), 16'($urandom % 512)};
         mem_rvalid = ($urandom % 3) == 0;
         mem_rdata  = {32'($urandom), 32'($urandom)};
         tick();
      end
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule